// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns one parallel data word into an asynchronous serial frame on a single output line. A byte is handed over on a valid/ready handshake. The block then drives a low start bit and the data bits, least-significant bit first. An optional parity bit follows. The frame closes with a high stop interval of one, one and a half or two bit times. Between frames the line rests at the high (mark) level.

Bit timing comes from a divider that splits the system clock into half-bit ticks, with `CLKS_PER_BIT` clocks per bit. The half-bit resolution makes the 1.5-bit stop interval exact. The parity mode and stop length are static inputs. They are captured together with the byte, so the surrounding logic can change them while a frame is on the line.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_line` is high and `in_ready` is high.
- R2: A byte is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. From the next cycle, `tx_line` is low for exactly `CLKS_PER_BIT` cycles (start bit).
- R3: After the start bit, the `DATA_BITS` data bits go out least-significant first. Each bit lasts `CLKS_PER_BIT` cycles.
- R4: `parity_mode` selects the parity: 2'b00 none, 2'b01 even, 2'b10 odd, 2'b11 none. With even parity, the number of ones across the data bits and the parity bit is even. With odd parity, that number is odd.
- R5: When parity is enabled, the parity bit lasts `CLKS_PER_BIT` cycles. It sits between the last data bit and the stop interval. When parity is disabled, the stop interval follows the last data bit directly.
- R6: `stop_len` selects the stop interval: 2'b00 one bit, 2'b01 one and a half bits, 2'b10 or 2'b11 two bits. `tx_line` is high for the whole interval. `in_ready` goes high in the first cycle after the interval ends.
- R7: `in_ready` is low from the cycle after acceptance until the stop interval ends. While it is low, `in_valid` and `in_data` have no effect on `tx_line`.
- R8: `parity_mode` and `stop_len` are sampled when a byte is accepted. Changing them during the frame does not affect that frame.
- R9: A byte presented in the first cycle that `in_ready` is high again is accepted at once. Its start bit follows the previous stop interval with no extra idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | DATA_BITS | Byte to send |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_ready | output | 1 | Transmitter can accept a byte this cycle |
| parity_mode | input | 2 | Parity selection (none/even/odd) |
| stop_len | input | 2 | Stop interval length selection |
| tx_line | output | 1 | Serial output line, high when idle |

## Verification
The bench checks both edges of the stop interval for each length, so a design that miscounts the 1.5-bit case shows up. Such a design would either release `in_ready` half a bit early or hold it half a bit too long. Even and odd parity are each tested with both data weights. An inverted or misplaced parity bit is caught at the parity slot's midpoint. In one frame, the bench keeps `in_valid` high with different data and flips the settings while the frame is on the line. A design that accepts a byte while busy, or reads the settings live, would corrupt that frame's bits or its stop length. Frames are also sent back to back, and a reset is applied mid-frame to show the line returns to mark at once.

// File: rtl/sftx_pkg.sv
// Package: shared encodings for the serial frame transmitter.
// Assumes: the 2-bit setting codes are fixed by the block's requirements.
package sftx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE     = 2'b00,
        PAR_EVEN     = 2'b01,
        PAR_ODD      = 2'b10,
        PAR_NONE_ALT = 2'b11
    } parity_mode_e;

    typedef enum logic [1:0] {
        STOP_ONE      = 2'b00,
        STOP_ONE_HALF = 2'b01,
        STOP_TWO      = 2'b10,
        STOP_TWO_ALT  = 2'b11
    } stop_len_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    // Number of half-bit periods in a stop interval for a given setting.
    function automatic logic [2:0] stop_halves(input stop_len_e sel);
        case (sel)
            STOP_ONE:      return 3'd2;
            STOP_ONE_HALF: return 3'd3;
            default:       return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/sftx_half_tick.sv
// Module: half-bit tick generator.
// Produces a one-cycle pulse every CLKS_PER_BIT/2 clocks while run is high.
// The phase restarts each time run rises, so the first tick comes exactly
// half a bit after run goes high.
// Assumes: CLKS_PER_BIT is even and at least 4.
module sftx_half_tick #(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic half_tick
);

    localparam int HALF = CLKS_PER_BIT / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    assign half_tick = run && (cnt == CW'(HALF - 1));

    // Count clocks within the current half-bit; hold at zero when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || half_tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n) half_tick |=> !half_tick); // R2

endmodule

// File: rtl/sftx_frame_ctrl.sv
// Module: frame sequencer and shift register.
// Accepts a byte on the handshake, latches the settings, then steps through
// the start, data, parity and stop symbols on half-bit ticks.
// halves_left holds the number of half-bit ticks left in the current symbol.
// Assumes: half_tick comes from a divider that runs while busy is high, and
// DATA_BITS is at least 2.
module sftx_frame_ctrl
    import sftx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_BITS-1:0] in_data,
    input  logic                 in_valid,
    input  logic [1:0]           parity_mode,
    input  logic [1:0]           stop_len,
    input  logic                 half_tick,
    output logic                 in_ready,
    output logic                 busy,
    output logic                 tx_line
);

    localparam int IW = $clog2(DATA_BITS);
    localparam logic [IW-1:0] LAST_IDX = IW'(DATA_BITS - 1);

    tx_state_e            state;
    logic [DATA_BITS-1:0] shreg;
    logic [IW-1:0]        bit_idx;
    logic [2:0]           halves_left;
    logic [2:0]           stop_cnt;
    logic                 par_en;
    logic                 par_bit;
    logic                 tx_q;
    logic                 accept;
    logic                 sym_end;
    parity_mode_e         pm_in;

    assign pm_in    = parity_mode_e'(parity_mode);
    assign in_ready = (state == ST_IDLE);
    assign busy     = (state != ST_IDLE);
    assign accept   = in_valid && in_ready;
    assign sym_end  = half_tick && (halves_left == 3'd1);
    assign tx_line  = tx_q;

    // Sequence the frame: latch byte and settings, then advance per symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            shreg       <= '0;
            bit_idx     <= '0;
            halves_left <= 3'd0;
            stop_cnt    <= 3'd2;
            par_en      <= 1'b0;
            par_bit     <= 1'b0;
            tx_q        <= 1'b1;
        end else if (state == ST_IDLE) begin
            if (accept) begin
                state       <= ST_START;
                tx_q        <= 1'b0;
                shreg       <= in_data;
                bit_idx     <= '0;
                halves_left <= 3'd2;
                par_en      <= (pm_in == PAR_EVEN) || (pm_in == PAR_ODD);
                par_bit     <= (^in_data) ^ (pm_in == PAR_ODD);
                stop_cnt    <= stop_halves(stop_len_e'(stop_len));
            end
        end else if (half_tick && !sym_end) begin
            halves_left <= halves_left - 3'd1;
        end else if (sym_end) begin
            case (state)
                ST_START: begin
                    state       <= ST_DATA;
                    tx_q        <= shreg[0];
                    halves_left <= 3'd2;
                end
                ST_DATA: begin
                    if (bit_idx != LAST_IDX) begin
                        bit_idx     <= bit_idx + 1'b1;
                        shreg       <= shreg >> 1;
                        tx_q        <= shreg[1];
                        halves_left <= 3'd2;
                    end else if (par_en) begin
                        state       <= ST_PARITY;
                        tx_q        <= par_bit;
                        halves_left <= 3'd2;
                    end else begin
                        state       <= ST_STOP;
                        tx_q        <= 1'b1;
                        halves_left <= stop_cnt;
                    end
                end
                ST_PARITY: begin
                    state       <= ST_STOP;
                    tx_q        <= 1'b1;
                    halves_left <= stop_cnt;
                end
                default: begin
                    state <= ST_IDLE;
                    tx_q  <= 1'b1;
                end
            endcase
        end
    end

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> !tx_q); // R2
    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n) (!busy && $past(!busy)) |-> tx_q); // R1
    AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_STOP) |-> tx_q); // R6
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> ($stable(par_en) && $stable(stop_cnt) && $stable(par_bit))); // R8
    AST_HALVES_RANGE: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (halves_left >= 3'd1 && halves_left <= 3'd4)); // R6

endmodule

// File: rtl/serial_frame_tx.sv
// Module: asynchronous serial frame transmitter, top level.
// Joins the half-bit tick generator to the frame sequencer.
// Assumes: CLKS_PER_BIT is even and at least 4, DATA_BITS at least 2.
module serial_frame_tx #(
    parameter int DATA_BITS    = 8,
    parameter int CLKS_PER_BIT = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_BITS-1:0] in_data,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [1:0]           parity_mode,
    input  logic [1:0]           stop_len,
    output logic                 tx_line
);

    logic half_tick;
    logic busy;

    sftx_half_tick #(
        .CLKS_PER_BIT(CLKS_PER_BIT)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .half_tick (half_tick)
    );

    sftx_frame_ctrl #(
        .DATA_BITS(DATA_BITS)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_data     (in_data),
        .in_valid    (in_valid),
        .parity_mode (parity_mode),
        .stop_len    (stop_len),
        .half_tick   (half_tick),
        .in_ready    (in_ready),
        .busy        (busy),
        .tx_line     (tx_line)
    );

    AST_READY_LINE: assert property (@(posedge clk) disable iff (!rst_n) (in_ready && $past(in_ready)) |-> tx_line); // R1

endmodule

// File: tb/serial_frame_tx_tb.sv
// Bench: walks a vector table of frames, then runs directed tests for
// settings changed during a frame and for a reset applied mid-frame.
module serial_frame_tx_tb;

    localparam int CPB  = 8;
    localparam int HALF = CPB / 2;
    localparam int NB   = 8;
    localparam int NV   = 7;

    // {data, parity_mode, stop_len, has_parity, parity_bit, stop_halves}
    localparam logic [16:0] VEC [0:NV-1] = '{
        {8'h55, 2'b00, 2'b00, 1'b0, 1'b0, 3'd2},
        {8'hA5, 2'b01, 2'b00, 1'b1, 1'b0, 3'd2},
        {8'h07, 2'b01, 2'b01, 1'b1, 1'b1, 3'd3},
        {8'h07, 2'b10, 2'b10, 1'b1, 1'b0, 3'd4},
        {8'h00, 2'b10, 2'b11, 1'b1, 1'b1, 3'd4},
        {8'hFF, 2'b11, 2'b01, 1'b0, 1'b0, 3'd3},
        {8'h80, 2'b01, 2'b00, 1'b1, 1'b1, 3'd2}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NB-1:0] in_data;
    logic          in_valid;
    logic          in_ready;
    logic [1:0]    parity_mode;
    logic [1:0]    stop_len;
    logic          tx_line;

    int errors = 0;
    int checks = 0;
    int cur    = 0;

    always #5 clk = ~clk;

    serial_frame_tx #(
        .DATA_BITS    (NB),
        .CLKS_PER_BIT (CPB)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_data     (in_data),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .parity_mode (parity_mode),
        .stop_len    (stop_len),
        .tx_line     (tx_line)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at t=%0t", req, act, exp, $time);
        end
    endtask

    // Advance to the negedge that follows posedge number n after acceptance.
    task automatic goto_n(input int n);
        repeat (n - cur) @(posedge clk);
        @(negedge clk);
        cur = n;
    endtask

    // Send one frame and check every symbol; call at a negedge.
    task automatic run_frame(input logic [NB-1:0] d, input logic [1:0] m,
                             input logic [1:0] s, input logic haspar,
                             input logic pbit, input int halves, input bit disturb);
        int    sb;
        int    endn;
        string dtag;
        dtag        = disturb ? "R8 R7" : "R3";
        in_data     = d;
        parity_mode = m;
        stop_len    = s;
        in_valid    = 1'b1;
        chk("R9", in_ready, 1'b1);
        @(posedge clk);
        @(negedge clk);
        cur = 0;
        chk("R7", in_ready, 1'b0);
        if (disturb) begin
            in_data     = ~d;
            parity_mode = (m == 2'b00) ? 2'b10 : 2'b00;
            stop_len    = (s == 2'b00) ? 2'b10 : 2'b00;
        end else begin
            in_valid = 1'b0;
        end
        goto_n(HALF);
        chk("R2", tx_line, 1'b0);
        goto_n(CPB - 1);
        chk("R2", tx_line, 1'b0);
        for (int k = 0; k < NB; k++) begin
            goto_n((k + 1) * CPB + HALF);
            chk(dtag, tx_line, d[k]);
        end
        sb = (1 + NB) * CPB;
        if (haspar) begin
            goto_n(sb + HALF);
            chk("R5 R4", tx_line, pbit);
            sb = sb + CPB;
        end
        endn = sb + halves * HALF;
        goto_n(sb + 1);
        chk("R6", tx_line, 1'b1);
        goto_n(endn - 1);
        chk("R6", in_ready, 1'b0);
        chk("R6", tx_line, 1'b1);
        in_valid = 1'b0;
        goto_n(endn);
        chk("R6", in_ready, 1'b1);
        chk("R1", tx_line, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        in_valid    = 1'b0;
        in_data     = '0;
        parity_mode = 2'b00;
        stop_len    = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", tx_line, 1'b1);
        chk("R1", in_ready, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);

        // Table frames, sent back to back (R9).
        for (int i = 0; i < NV; i++) begin
            run_frame(VEC[i][16:9], VEC[i][8:7], VEC[i][6:5], VEC[i][4],
                      VEC[i][3], int'(VEC[i][2:0]), 1'b0);
        end

        // Settings and data disturbed while busy (R7, R8): even, 1.5 stop.
        run_frame(8'h3C, 2'b01, 2'b01, 1'b1, 1'b0, 3, 1'b1);

        // Idle gap, then line stays at mark (R1).
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R1", tx_line, 1'b1);

        // Reset in the middle of a frame returns to idle (R1).
        in_data  = 8'h00;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk("R3", tx_line, 1'b0);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1", tx_line, 1'b1);
        chk("R1", in_ready, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);

        // A normal frame after the mid-frame reset: odd parity, two stop bits.
        run_frame(8'hC3, 2'b10, 2'b10, 1'b1, 1'b1, 4, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule